// File: doc/BRIEF.md
# Micro-Stepped Accumulator Processor Sequencer

This block is a small one-address processor whose control is a timed sequencer of register-transfer steps, one step per clock. It holds a program counter, a memory address register, a memory buffer register, an instruction register, a single accumulator and a status word. Every instruction runs the same frame: a fetch sub-cycle, an indirect sub-cycle when the instruction asks for one, an execute sub-cycle chosen by the opcode, and an interrupt sub-cycle when a request is pending and enabled.

The block owns a simple memory port. The address always comes from the memory address register and write data always comes from the memory buffer register. Read data must be valid in the same step that the address is presented. Results are visible on the accumulator, program counter and status outputs, and a halted flag shows when the program has stopped.

Words are 16 bits. Bits 15:12 hold the opcode, bit 11 is the indirect flag and bits 10:0 are the address. The opcodes are 0 for add, 1 for increment-and-skip-if-zero, 2 for branch-and-save-return, 3 for halt, 4 for interrupts on and 5 for interrupts off. Every other opcode is a no-op.

Top module: `acc_seq_cpu`

## Requirements
- R1: While rst_n is low, pc_out is 0x010, acc_out is 0, status_out is 0, halted is 0 and mem_we is 0. After release the first step is fetch step 1.
- R2: Fetch takes three clocks, in this order: MAR takes PC; then MBR takes mem_rdata and PC increments by one; then IR takes MBR. A direct add therefore needs 6 clocks and a halt needs 4 clocks until halted is set.
- R3: When IR bit 11 is set, an indirect cycle of three clocks follows the fetch: MAR takes the IR address; then MBR takes memory; then IR[10:0] takes MBR[10:0]. Execution then proceeds as for direct addressing, with the pointer word as the operand address.
- R4: Add (opcode 0) takes three clocks: MAR takes the address, MBR takes memory, then the accumulator takes accumulator plus MBR, modulo 2^16.
- R5: status_out is {interrupt enable, sign, zero, carry, overflow} from bit 4 down to bit 0. Only add updates bits 3:0. Sign is result bit 15, zero means the result is 0, carry is the unsigned carry out, and overflow is signed overflow.
- R6: Increment-and-skip (opcode 1) takes four clocks. It reads the word and adds one to it in MBR. In the last step it writes MBR back to the same address and, in that same step, increments PC once more if the new value is zero.
- R7: Branch-and-save (opcode 2) takes three clocks. It stores the return PC (the address after the branch-and-save instruction, zero-extended) at address X, loads PC with X and then increments it, so execution resumes at X+1.
- R8: Halt (opcode 3) sets halted after one execute clock. From then on pc_out and all registers hold and there are no memory writes until reset.
- R9: Opcode 4 sets interrupt enable and opcode 5 clears it, each in one execute clock. Opcodes 6 to 15 leave every register except PC unchanged.
- R10: The interrupt cycle takes three clocks. It copies PC into MBR and clears interrupt enable; then MAR takes 0x000 and PC takes 0x001; then MBR is written to address 0x000. The next fetch takes the instruction at 0x001.
- R11: irq is sampled only in the last step of an execute cycle, and only with the interrupt enable bit as it stood at the start of that step. When interrupt enable is clear, irq has no effect.
- R12: mem_we is asserted only in the write step of increment-and-skip, of branch-and-save and of the interrupt cycle, one clock each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq | input | 1 | Interrupt request level |
| mem_addr | output | 11 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (MBR) |
| mem_we | output | 1 | Memory write strobe, the write takes effect at the clock edge |
| mem_rdata | input | 16 | Memory read data for mem_addr, valid in the same step |
| acc_out | output | 16 | Accumulator |
| pc_out | output | 11 | Program counter |
| status_out | output | 5 | {ie, sign, zero, carry, overflow} |
| halted | output | 1 | Program stopped by halt |

## Verification
Each instruction's result becomes visible at a clock edge that follows from its step counts. A direct add settles after six edges, an indirect one after nine, and a halt raises halted four edges after its fetch begins. The bench therefore counts edges from the release of reset to halted and compares that count with the sum of the expected step counts. All register results are sampled one time unit after an edge, once halted is set. Memory results from skip, branch-and-save and interrupt saves are read from the bench's memory array after the run, together with the number of write strobes seen.

// File: rtl/acc_seq_pkg.sv
// Package: shared types for the accumulator sequencer.
// Holds the sub-cycle phase encoding, opcode values and the micro-operation
// control word passed from the sequencer to the datapath.
package acc_seq_pkg;

    localparam int OP_W = 4;

    localparam logic [OP_W-1:0] OPC_ADD  = 4'd0;
    localparam logic [OP_W-1:0] OPC_ISZ  = 4'd1;
    localparam logic [OP_W-1:0] OPC_BSA  = 4'd2;
    localparam logic [OP_W-1:0] OPC_HALT = 4'd3;
    localparam logic [OP_W-1:0] OPC_ION  = 4'd4;
    localparam logic [OP_W-1:0] OPC_IOF  = 4'd5;

    typedef enum logic [2:0] {
        PH_FETCH = 3'd0,
        PH_INDIR = 3'd1,
        PH_EXEC  = 3'd2,
        PH_INTR  = 3'd3,
        PH_HALT  = 3'd4
    } phase_t;

    typedef struct packed {
        logic mar_pc;     // MAR <- PC
        logic mar_ir;     // MAR <- IR address
        logic mar_save;   // MAR <- save address
        logic mbr_mem;    // MBR <- memory
        logic mbr_pc;     // MBR <- PC
        logic mbr_inc;    // MBR <- MBR + 1
        logic ir_mbr;     // IR <- MBR
        logic iradr_mbr;  // IR address <- MBR address bits
        logic pc_inc;     // PC <- PC + 1
        logic pc_ir;      // PC <- IR address
        logic pc_hdl;     // PC <- handler address
        logic pc_skipz;   // PC <- PC + 1 if MBR is zero
        logic mem_we;     // memory <- MBR
        logic r1_add;     // R1 <- R1 + MBR, flags updated
        logic ie_set;     // interrupt enable on
        logic ie_clr;     // interrupt enable off
    } uop_t;

endpackage

// File: rtl/acc_seq_add.sv
// Module: acc_seq_add
// Adds two W-bit words and produces sign, zero, carry and signed overflow.
// Assumes two's-complement operands; purely combinational.
module acc_seq_add #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic [3:0]   flags   // {sign, zero, carry, overflow}
);
    logic [W:0] wide;

    // Full-width sum with carry out and flag derivation.
    always_comb begin
        wide  = {1'b0, a} + {1'b0, b};
        sum   = wide[W-1:0];
        flags = {wide[W-1],
                 (wide[W-1:0] == '0),
                 wide[W],
                 (a[W-1] == b[W-1]) && (wide[W-1] != a[W-1])};
    end
endmodule

// File: rtl/acc_seq_ctrl.sv
// Module: acc_seq_ctrl
// Timed micro-operation sequencer. Tracks the sub-cycle (fetch, indirect,
// execute, interrupt, halted) and the step inside it, and emits one control
// word per clock. Assumes the datapath applies the word at the next edge and
// that memory read data is valid in the step that presents the address.
module acc_seq_ctrl
    import acc_seq_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op,        // opcode from IR
    input  logic            mbr_ind,   // indirect bit of the word in MBR
    input  logic            irq,
    input  logic            ie,
    output phase_t          phase,
    output logic [STEP_W-1:0] step,
    output uop_t            uop
);
    phase_t            phase_q, phase_d;
    logic [STEP_W-1:0] step_q, step_d;
    logic              last;

    // Decode the current step into micro-operations and the next step.
    always_comb begin
        uop     = '0;
        phase_d = phase_q;
        step_d  = step_q + 1'b1;
        last    = 1'b0;
        case (phase_q)
            PH_FETCH: begin
                case (step_q)
                    2'd0: uop.mar_pc = 1'b1;
                    2'd1: begin
                        uop.mbr_mem = 1'b1;
                        uop.pc_inc  = 1'b1;
                    end
                    default: begin
                        uop.ir_mbr = 1'b1;
                        phase_d    = mbr_ind ? PH_INDIR : PH_EXEC;
                        step_d     = '0;
                    end
                endcase
            end
            PH_INDIR: begin
                case (step_q)
                    2'd0: uop.mar_ir  = 1'b1;
                    2'd1: uop.mbr_mem = 1'b1;
                    default: begin
                        uop.iradr_mbr = 1'b1;
                        phase_d       = PH_EXEC;
                        step_d        = '0;
                    end
                endcase
            end
            PH_EXEC: begin
                case (op)
                    OPC_ADD: begin
                        case (step_q)
                            2'd0: uop.mar_ir  = 1'b1;
                            2'd1: uop.mbr_mem = 1'b1;
                            default: begin
                                uop.r1_add = 1'b1;
                                last       = 1'b1;
                            end
                        endcase
                    end
                    OPC_ISZ: begin
                        case (step_q)
                            2'd0: uop.mar_ir  = 1'b1;
                            2'd1: uop.mbr_mem = 1'b1;
                            2'd2: uop.mbr_inc = 1'b1;
                            default: begin
                                uop.mem_we   = 1'b1;
                                uop.pc_skipz = 1'b1;
                                last         = 1'b1;
                            end
                        endcase
                    end
                    OPC_BSA: begin
                        case (step_q)
                            2'd0: begin
                                uop.mar_ir = 1'b1;
                                uop.mbr_pc = 1'b1;
                            end
                            2'd1: begin
                                uop.pc_ir  = 1'b1;
                                uop.mem_we = 1'b1;
                            end
                            default: begin
                                uop.pc_inc = 1'b1;
                                last       = 1'b1;
                            end
                        endcase
                    end
                    OPC_HALT: begin
                        phase_d = PH_HALT;
                        step_d  = '0;
                    end
                    OPC_ION: begin
                        uop.ie_set = 1'b1;
                        last       = 1'b1;
                    end
                    OPC_IOF: begin
                        uop.ie_clr = 1'b1;
                        last       = 1'b1;
                    end
                    default: last = 1'b1;
                endcase
                if (last) begin
                    phase_d = (irq && ie) ? PH_INTR : PH_FETCH;
                    step_d  = '0;
                end
            end
            PH_INTR: begin
                case (step_q)
                    2'd0: begin
                        uop.mbr_pc = 1'b1;
                        uop.ie_clr = 1'b1;
                    end
                    2'd1: begin
                        uop.mar_save = 1'b1;
                        uop.pc_hdl   = 1'b1;
                    end
                    default: begin
                        uop.mem_we = 1'b1;
                        phase_d    = PH_FETCH;
                        step_d     = '0;
                    end
                endcase
            end
            default: step_d = step_q;   // halted: hold
        endcase
    end

    // Advance the phase and step registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
            step_q  <= '0;
        end else begin
            phase_q <= phase_d;
            step_q  <= step_d;
        end
    end

    assign phase = phase_q;
    assign step  = step_q;
endmodule

// File: rtl/acc_seq_dp.sv
// Module: acc_seq_dp
// Register datapath: PC, MAR, MBR, IR, accumulator, flags and interrupt
// enable. Applies the control word from the sequencer at each clock edge.
// Assumes at most one source is selected per register in any step.
module acc_seq_dp
    import acc_seq_pkg::*;
#(
    parameter int              DATA_W       = 16,
    parameter int              ADDR_W       = 11,
    parameter logic [ADDR_W-1:0] RESET_PC     = 11'h010,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 11'h000,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  uop_t              uop,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] add_sum,
    input  logic [3:0]        add_flags,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] mar,
    output logic [DATA_W-1:0] mbr,
    output logic [DATA_W-1:0] ir,
    output logic [DATA_W-1:0] r1,
    output logic [3:0]        flags,
    output logic              ie
);
    localparam int PAD_W = DATA_W - ADDR_W;

    logic mbr_zero;
    assign mbr_zero = (mbr == '0);

    // Program counter: handler load, branch target, or increment/skip.
    always_ff @(posedge clk) begin
        if (!rst_n)                              pc <= RESET_PC;
        else if (uop.pc_hdl)                     pc <= HANDLER_ADDR;
        else if (uop.pc_ir)                      pc <= ir[ADDR_W-1:0];
        else if (uop.pc_inc || (uop.pc_skipz && mbr_zero))
                                                 pc <= pc + 1'b1;
    end

    // Memory address register sources.
    always_ff @(posedge clk) begin
        if (!rst_n)              mar <= '0;
        else if (uop.mar_pc)     mar <= pc;
        else if (uop.mar_ir)     mar <= ir[ADDR_W-1:0];
        else if (uop.mar_save)   mar <= SAVE_ADDR;
    end

    // Memory buffer register: read data, saved PC, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n)              mbr <= '0;
        else if (uop.mbr_mem)    mbr <= mem_rdata;
        else if (uop.mbr_pc)     mbr <= {{PAD_W{1'b0}}, pc};
        else if (uop.mbr_inc)    mbr <= mbr + 1'b1;
    end

    // Instruction register: whole word or address field replacement.
    always_ff @(posedge clk) begin
        if (!rst_n)              ir <= '0;
        else if (uop.ir_mbr)     ir <= mbr;
        else if (uop.iradr_mbr)  ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
    end

    // Accumulator and arithmetic flags, written only by add.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r1    <= '0;
            flags <= '0;
        end else if (uop.r1_add) begin
            r1    <= add_sum;
            flags <= add_flags;
        end
    end

    // Interrupt enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n)              ie <= 1'b0;
        else if (uop.ie_clr)     ie <= 1'b0;
        else if (uop.ie_set)     ie <= 1'b1;
    end
endmodule

// File: rtl/acc_seq_cpu.sv
// Module: acc_seq_cpu (top)
// One-address accumulator processor driven by a micro-step sequencer.
// Word layout: opcode in the top OP_W bits, indirect flag below it, address
// in the low ADDR_W bits; DATA_W must equal OP_W + 1 + ADDR_W. Assumes a
// memory whose read data is valid in the step the address is presented and
// whose write lands at the clock edge ending a step with mem_we high.
module acc_seq_cpu
    import acc_seq_pkg::*;
#(
    parameter int              DATA_W       = 16,
    parameter int              ADDR_W       = 11,
    parameter logic [ADDR_W-1:0] RESET_PC     = 11'h010,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 11'h000,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_out,
    output logic [ADDR_W-1:0] pc_out,
    output logic [4:0]        status_out,
    output logic              halted
);
    localparam int STEP_W = 2;

    phase_t            phase_q;
    logic [STEP_W-1:0] step_q;
    uop_t              uop;
    logic [ADDR_W-1:0] pc, mar;
    logic [DATA_W-1:0] mbr, ir, r1, add_sum;
    logic [3:0]        flags, add_flags;
    logic              ie;

    acc_seq_ctrl #(.STEP_W(STEP_W)) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (ir[DATA_W-1 -: OP_W]),
        .mbr_ind (mbr[ADDR_W]),
        .irq     (irq),
        .ie      (ie),
        .phase   (phase_q),
        .step    (step_q),
        .uop     (uop)
    );

    acc_seq_dp #(
        .DATA_W       (DATA_W),
        .ADDR_W       (ADDR_W),
        .RESET_PC     (RESET_PC),
        .SAVE_ADDR    (SAVE_ADDR),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .uop       (uop),
        .mem_rdata (mem_rdata),
        .add_sum   (add_sum),
        .add_flags (add_flags),
        .pc        (pc),
        .mar       (mar),
        .mbr       (mbr),
        .ir        (ir),
        .r1        (r1),
        .flags     (flags),
        .ie        (ie)
    );

    acc_seq_add #(.W(DATA_W)) i_add (
        .a     (r1),
        .b     (mbr),
        .sum   (add_sum),
        .flags (add_flags)
    );

    assign mem_addr   = mar;
    assign mem_wdata  = mbr;
    assign mem_we     = uop.mem_we;
    assign acc_out    = r1;
    assign pc_out     = pc;
    assign status_out = {ie, flags};
    assign halted     = (phase_q == PH_HALT);
endmodule

// File: rtl/acc_seq_cpu_chk.sv
// Module: acc_seq_cpu_chk
// Property checker bound into acc_seq_cpu; observes ports and the sequencer
// state. Assumes synchronous active-low reset.
module acc_seq_cpu_chk
    import acc_seq_pkg::*;
#(
    parameter int              ADDR_W       = 11,
    parameter logic [ADDR_W-1:0] SAVE_ADDR    = 11'h000,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 11'h001
) (
    input logic              clk,
    input logic              rst_n,
    input phase_t            phase,
    input logic [1:0]        step,
    input uop_t              uop,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [ADDR_W-1:0] pc_out,
    input logic [4:0]        status_out,
    input logic              halted
);
    // R12
    write_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (phase == PH_EXEC || phase == PH_INTR));

    // R10
    save_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && phase == PH_INTR) |-> (mem_addr == SAVE_ADDR));

    // R10
    handler_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INTR && step == 2'd1) |=> (pc_out == HANDLER_ADDR));

    // R10
    ie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_INTR) |=> !status_out[4]);

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc_out) && !mem_we));

    // R5
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_out[3:0] != $past(status_out[3:0])) |-> $past(uop.r1_add));

    // R2
    fetch_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FETCH && step == 2'd1) |=>
        (pc_out == ADDR_W'($past(pc_out) + 1'b1)));
endmodule

bind acc_seq_cpu acc_seq_cpu_chk #(
    .ADDR_W       (ADDR_W),
    .SAVE_ADDR    (SAVE_ADDR),
    .HANDLER_ADDR (HANDLER_ADDR)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase_q),
    .step       (step_q),
    .uop        (uop),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .pc_out     (pc_out),
    .status_out (status_out),
    .halted     (halted)
);

// File: tb/test_acc_seq_cpu.sv
// Bench: test_acc_seq_cpu
// Drives programs held in a bench memory array through acc_seq_cpu and
// compares results with values computed by bench functions.
module test_acc_seq_cpu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [10:0] mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        mem_we;
    logic [15:0] acc_out;
    logic [10:0] pc_out;
    logic [4:0]  status_out;
    logic        halted;

    logic [15:0] mem [0:2047];
    int          n_chk = 0;
    int          n_err = 0;
    int          wr_cnt;
    int          run_cyc;
    logic [15:0] dq [8];
    bit          iq [8];

    always #4 clk = ~clk;   // 125 MHz

    acc_seq_cpu i_acc_seq_cpu (
        .clk(clk), .rst_n(rst_n), .irq(irq),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .acc_out(acc_out), .pc_out(pc_out),
        .status_out(status_out), .halted(halted)
    );

    assign mem_rdata = mem[mem_addr];

    // Behavioural memory write port and write-strobe counter.
    always @(posedge clk) begin
        if (!rst_n) wr_cnt <= 0;
        else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] add_flags(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        return {s[15], s[15:0] == 16'h0, s[16], (a[15] == b[15]) && (s[15] != a[15])};
    endfunction

    task automatic clear_mem();
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0;
    endtask

    // Reset, check the reset state, release and run until halted.
    task automatic run();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 pc", 32'(pc_out), 32'h010);
        chk("R1 acc", 32'(acc_out), 32'h0);
        chk("R1 status", 32'(status_out), 32'h0);
        chk("R1 halt/we", {halted, mem_we}, 32'h0);
        @(negedge clk) rst_n = 1'b1;
        run_cyc = 0;
        while (!halted && run_cyc < 3000) begin
            @(posedge clk);
            run_cyc++;
            #1;
        end
        chk("R8 halted reached", 32'(halted), 32'h1);
    endtask

    // Program of n adds (direct or indirect) then halt; checks sum, flags, timing.
    task automatic run_adds(input int n, input string tag);
        logic [15:0] acc;
        logic [3:0]  fl;
        int          cyc;
        clear_mem();
        acc = 16'h0; fl = 4'h0; cyc = 4;
        for (int i = 0; i < n; i++) begin
            if (iq[i]) begin
                mem[11'h010 + i] = 16'h0800 | (16'h100 + 16'(i));
                mem[11'h100 + i] = 16'h200 + 16'(i);
                mem[11'h200 + i] = dq[i];
                cyc += 9;
            end else begin
                mem[11'h010 + i] = 16'h100 + 16'(i);
                mem[11'h100 + i] = dq[i];
                cyc += 6;
            end
            fl  = add_flags(acc, dq[i]);
            acc = acc + dq[i];
        end
        mem[11'h010 + n] = 16'h3000;
        run();
        chk({"R4 acc ", tag}, 32'(acc_out), 32'(acc));
        chk({"R5 flags ", tag}, 32'(status_out), {27'h0, 1'b0, fl});
        chk({"R2 R3 cycles ", tag}, 32'(run_cyc), 32'(cyc));
        chk({"R8 pc ", tag}, 32'(pc_out), 32'h011 + 32'(n));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R2 watchdog act=%0d exp=<150000", 150000);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin : main
        logic [10:0] pc_h;
        void'($urandom(32'd20231));

        // R4/R5 directed: signed overflow, then carry to zero, then one indirect.
        dq[0] = 16'h7FFF; dq[1] = 16'h0001; iq[0] = 0; iq[1] = 0;
        run_adds(2, "ovf");
        dq[0] = 16'hFFFF; dq[1] = 16'h0001; iq[0] = 0; iq[1] = 1;
        run_adds(2, "carry");

        // R3/R4/R5 random operand and addressing mixes.
        for (int t = 0; t < 6; t++) begin
            int n;
            n = 1 + int'($urandom % 8);
            for (int i = 0; i < 8; i++) begin
                dq[i] = 16'($urandom);
                iq[i] = bit'($urandom % 2);
            end
            run_adds(n, "rand");
        end

        // R6: skip when the incremented word is zero, no skip otherwise.
        clear_mem();
        mem[11'h010] = 16'h1300; mem[11'h011] = 16'h0301;
        mem[11'h012] = 16'h1302; mem[11'h013] = 16'h0303;
        mem[11'h014] = 16'h3000;
        mem[11'h300] = 16'hFFFF; mem[11'h301] = 16'h0005;
        mem[11'h302] = 16'h0007; mem[11'h303] = 16'h0001;
        run();
        chk("R6 wrap to zero", 32'(mem[11'h300]), 32'h0);
        chk("R6 increment", 32'(mem[11'h302]), 32'h8);
        chk("R6 skipped add", 32'(acc_out), 32'h1);
        chk("R6 pc", 32'(pc_out), 32'h015);
        chk("R12 writes isz", 32'(wr_cnt), 32'd2);

        // R7: branch-and-save stores return PC and resumes at X+1.
        clear_mem();
        mem[11'h010] = 16'h2040; mem[11'h011] = 16'h3000;
        mem[11'h041] = 16'h0300; mem[11'h042] = 16'h3000;
        mem[11'h300] = 16'h0009;
        run();
        chk("R7 return addr", 32'(mem[11'h040]), 32'h0011);
        chk("R7 acc", 32'(acc_out), 32'h9);
        chk("R7 pc", 32'(pc_out), 32'h043);
        chk("R12 writes bsa", 32'(wr_cnt), 32'd1);

        // R8: after halt nothing moves.
        pc_h = pc_out;
        repeat (10) @(posedge clk);
        #1;
        chk("R8 hold pc", 32'(pc_out), 32'(pc_h));
        chk("R8 no write", 32'(wr_cnt), 32'd1);

        // R10/R11/R9: interrupt taken after the instruction following enable.
        clear_mem();
        mem[11'h010] = 16'h4000; mem[11'h011] = 16'h0300;
        mem[11'h012] = 16'h0301; mem[11'h013] = 16'h3000;
        mem[11'h001] = 16'h0302; mem[11'h002] = 16'h3000;
        mem[11'h300] = 16'd3; mem[11'h301] = 16'd4; mem[11'h302] = 16'd100;
        irq = 1'b1;
        run();
        chk("R10 saved pc", 32'(mem[11'h000]), 32'h0012);
        chk("R10 handler acc", 32'(acc_out), 32'd103);
        chk("R10 handler pc", 32'(pc_out), 32'h003);
        chk("R10 ie cleared", 32'(status_out[4]), 32'h0);
        chk("R12 writes intr", 32'(wr_cnt), 32'd1);

        // R11/R9: disabled interrupts ignored; opcode 7 and 5 are no-ops.
        clear_mem();
        mem[11'h000] = 16'hBEEF;
        mem[11'h010] = 16'h7000; mem[11'h011] = 16'h0300;
        mem[11'h012] = 16'h5301; mem[11'h013] = 16'h0301;
        mem[11'h014] = 16'h3000;
        mem[11'h300] = 16'd3; mem[11'h301] = 16'd4;
        run();
        chk("R11 no save", 32'(mem[11'h000]), 32'hBEEF);
        chk("R9 R11 acc", 32'(acc_out), 32'd7);
        chk("R9 R11 pc", 32'(pc_out), 32'h015);
        chk("R9 ie off", 32'(status_out[4]), 32'h0);
        irq = 1'b0;

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule